// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Decode-Stage Branch Resolution

This block owns the program counter of a five-stage in-order pipeline (fetch, decode/register read, execute, memory, write-back). Each cycle it presents a fetch address to an instruction memory that answers combinationally. The returned word and its address are captured into the fetch/decode slot, which feeds the decode stage. A comparator in the decode stage returns a taken flag and a target address. The block recognises a branch only by its opcode field and never decodes further.

A two-bit mode input selects how the instruction fetched behind a branch is treated. In delay-slot mode that instruction always issues. In interlocked mode it is replaced by a bubble, so the branch costs one extra issue cycle. In the late-resolution mode the taken flag is produced one stage later, by the execute stage, and two fetched instructions are discarded. A bubble is an all-zero word with its valid bit low, and a downstream stage must not write any state for it. A stall input from hazard logic freezes the block for a cycle.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0x00000000 and clears the decode slot: the valid flag is 0 and the word is 0.
- R2: When nothing stalls or discards, the fetch address advances by 4 each cycle. The word fetched in one cycle appears in the decode slot on the next cycle, valid, together with the address it was fetched from.
- R3: A valid slot word whose bits [31:26] equal 6'b000100 is a branch. For any other slot content, the taken flag and target are ignored and the fetch address still advances by 4.
- R4: Mode 2'b00 (delay slot): while a branch sits in the decode slot, the instruction fetched in that cycle issues valid. If taken, the target is fetched in the next cycle, with no bubble.
- R5: Mode 2'b01 (interlocked): the instruction fetched behind a branch is replaced by one bubble. A taken branch then fetches the target. A not-taken branch refetches the address after the branch.
- R6: Modes 2'b10 and 2'b11 (late resolution): a branch in the decode slot is followed by two bubbles. The taken flag and target are sampled only in the cycle after the branch leaves the decode slot. The input during the branch's own decode cycle has no effect.
- R7: Whenever the decode slot is not valid, its instruction word is all zero.
- R8: A high stall input keeps the fetch address, the decode slot and any pending late-resolution decision unchanged for that cycle. This includes a cycle in which a taken branch would otherwise redirect; the redirect happens in the first cycle without stall.
- R9: For a fixed program with three branches, the count of decode cycles minus valid issues equals 0, 1 or 2 per branch for modes 00, 01 and 10/11 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Branch handling: 00 delay slot, 01 interlocked, 10/11 late resolution |
| stall_i | input | 1 | Freeze the fetch address and decode slot this cycle |
| br_taken_i | input | 1 | Branch outcome from the resolving comparator |
| br_target_i | input | 32 | Branch target byte address |
| imem_addr_o | output | 32 | Fetch address to instruction memory |
| imem_data_i | input | 32 | Instruction word returned for imem_addr_o in the same cycle |
| dec_valid_o | output | 1 | Decode slot holds a real instruction |
| dec_instr_o | output | 32 | Decode slot instruction word (zero when a bubble) |
| dec_pc_o | output | 32 | Address the decode slot word was fetched from |

## Verification
A stall and a taken branch redirect can both fall in the same cycle. A stall is raised while a taken branch sits in the decode slot with the comparator reporting taken. The bench expects the fetch address and the slot to stay unchanged through the stall. After the stall, it expects the delay-slot word in decode and the target on the fetch address one cycle later. A second overlap is checked in late-resolution mode: a taken flag forced high while the branch is still in decode must not move the fetch address.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned INSN_W = 32;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned INSN_BYTES = INSN_W / 8;

    typedef enum logic [1:0] {
        FSEQ_DELAY_SLOT = 2'b00,
        FSEQ_INTERLOCK  = 2'b01,
        FSEQ_LATE       = 2'b10,
        FSEQ_LATE_ALT   = 2'b11
    } fseq_mode_e;

    typedef struct packed {
        logic              valid;
        logic [INSN_W-1:0] insn;
        logic [ADDR_W-1:0] pc;
    } fseq_slot_t;

    typedef struct packed {
        logic redirect;   // load the branch target
        logic squash;     // write a bubble into the decode slot
        logic hold_pc;    // keep the fetch address (refetch)
        logic pend;       // a late-resolved branch waits in execute
    } fseq_ctl_t;

endpackage

// File: rtl/fseq_ctl.sv
`timescale 1ns/1ps
module fseq_ctl
    import fseq_pkg::*;
#(
    parameter logic [OPC_W-1:0] BR_OPC  = 6'b000100,
    parameter bit               LATE_EN = 1'b1
) (
    input  fseq_mode_e       mode_i,
    input  logic             slot_valid_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             pend_i,
    input  logic             br_taken_i,
    output fseq_ctl_t        ctl_o,
    output logic             slot_is_br_o
);

    logic late_sel;

    // The late-resolution variant can be left out; its modes then interlock.
    generate
        if (LATE_EN) begin : g_late
            assign late_sel = (mode_i == FSEQ_LATE) || (mode_i == FSEQ_LATE_ALT);
        end else begin : g_no_late
            assign late_sel = 1'b0;
        end
    endgenerate

    assign slot_is_br_o = slot_valid_i && (opcode_i == BR_OPC);

    always_comb begin
        ctl_o = '0;
        if (pend_i) begin
            // Second cycle of a late branch: the outcome is valid now.
            ctl_o.squash   = 1'b1;
            ctl_o.redirect = br_taken_i;
            ctl_o.hold_pc  = !br_taken_i;
        end else if (slot_is_br_o) begin
            if (late_sel) begin
                ctl_o.squash  = 1'b1;
                ctl_o.hold_pc = 1'b1;
                ctl_o.pend    = 1'b1;
            end else if (mode_i == FSEQ_DELAY_SLOT) begin
                ctl_o.redirect = br_taken_i;
            end else begin
                ctl_o.squash   = 1'b1;
                ctl_o.redirect = br_taken_i;
                ctl_o.hold_pc  = !br_taken_i;
            end
        end
    end

endmodule

// File: rtl/fseq_pc.sv
`timescale 1ns/1ps
module fseq_pc
    import fseq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              redirect_i,
    input  logic              hold_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] pc_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!stall_i) begin
            if (redirect_i) begin
                st_d.pc = target_i;
            end else if (!hold_i) begin
                st_d.pc = st_q.pc + STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pc: RESET_VEC};
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

    // R8: a stall wins over a redirect
    p_stall_beats_redirect_r8: assert property (@(posedge clk) disable iff (rst)
        (stall_i && redirect_i) |=> (pc_o == $past(pc_o)));

    // R8: stall freezes the fetch address
    p_pc_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(pc_o));

endmodule

// File: rtl/fseq_slot.sv
`timescale 1ns/1ps
module fseq_slot
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              squash_i,
    input  logic              pend_next_i,
    input  logic [INSN_W-1:0] fetch_insn_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output fseq_slot_t        slot_o,
    output logic              pend_o
);

    typedef struct packed {
        fseq_slot_t slot;
        logic       pend;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!stall_i) begin
            if (squash_i) begin
                st_d.slot = '0;
            end else begin
                st_d.slot.valid = 1'b1;
                st_d.slot.insn  = fetch_insn_i;
                st_d.slot.pc    = fetch_pc_i;
            end
            st_d.pend = pend_next_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;
    assign pend_o = st_q.pend;

    // R7: a bubble carries an all-zero word
    p_bubble_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !slot_o.valid |-> (slot_o.insn == '0));

    // R8: stall holds the slot and the pending decision
    p_slot_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(slot_o) && $stable(pend_o)));

    // R6: while a late branch waits in execute, decode sees a bubble
    p_pend_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        pend_o |-> !slot_o.valid);

endmodule

// File: rtl/fetch_seq.sv
`timescale 1ns/1ps
module fetch_seq
    import fseq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_0000,
    parameter logic [OPC_W-1:0]  BR_OPC    = 6'b000100,
    parameter bit                LATE_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              stall_i,
    input  logic              br_taken_i,
    input  logic [ADDR_W-1:0] br_target_i,
    output logic [ADDR_W-1:0] imem_addr_o,
    input  logic [INSN_W-1:0] imem_data_i,
    output logic              dec_valid_o,
    output logic [INSN_W-1:0] dec_instr_o,
    output logic [ADDR_W-1:0] dec_pc_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    fseq_mode_e mode;
    fseq_ctl_t  ctl;
    fseq_slot_t slot;
    logic       pend_q;
    logic       slot_is_br;
    logic [ADDR_W-1:0] pc_q;

    assign mode = fseq_mode_e'(mode_i);

    fseq_ctl #(
        .BR_OPC  (BR_OPC),
        .LATE_EN (LATE_EN)
    ) u_ctl (
        .mode_i       (mode),
        .slot_valid_i (slot.valid),
        .opcode_i     (slot.insn[INSN_W-1 -: OPC_W]),
        .pend_i       (pend_q),
        .br_taken_i   (br_taken_i),
        .ctl_o        (ctl),
        .slot_is_br_o (slot_is_br)
    );

    fseq_pc #(
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk        (clk),
        .rst        (rst),
        .stall_i    (stall_i),
        .redirect_i (ctl.redirect),
        .hold_i     (ctl.hold_pc),
        .target_i   (br_target_i),
        .pc_o       (pc_q)
    );

    fseq_slot u_slot (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall_i),
        .squash_i     (ctl.squash),
        .pend_next_i  (ctl.pend),
        .fetch_insn_i (imem_data_i),
        .fetch_pc_i   (pc_q),
        .slot_o       (slot),
        .pend_o       (pend_q)
    );

    assign imem_addr_o = pc_q;
    assign dec_valid_o = slot.valid;
    assign dec_instr_o = slot.insn;
    assign dec_pc_o    = slot.pc;

    // R1: reset state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!dec_valid_o && (imem_addr_o == RESET_VEC)));

    // R2: the fetched word arrives in decode with its address
    p_fetch_to_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !ctl.squash) |=> (dec_valid_o
            && (dec_pc_o == $past(imem_addr_o))
            && (dec_instr_o == $past(imem_data_i))));

    // R3: without a branch in decode the fetch address steps by 4
    p_nonbranch_steps_r3: assert property (@(posedge clk) disable iff (rst)
        (!slot_is_br && !pend_q && !stall_i) |=> (imem_addr_o == $past(imem_addr_o) + STEP));

    // R4: delay slot always issues
    p_delay_slot_issues_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == FSEQ_DELAY_SLOT && slot_is_br && !stall_i) |=> dec_valid_o);

    // R5: interlock inserts one bubble
    p_interlock_bubble_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == FSEQ_INTERLOCK && slot_is_br && !stall_i) |=> !dec_valid_o);

    // R6: late resolution holds the fetch address on the first cycle
    p_late_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1] && LATE_EN && slot_is_br && !pend_q && !stall_i)
            |=> (!dec_valid_o && $stable(imem_addr_o)));

endmodule

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'b00;
    logic        stall_i = 1'b0;
    logic        br_taken_i = 1'b0;
    logic [31:0] br_target_i = '0;
    logic [31:0] imem_addr_o;
    logic [31:0] imem_data_i;
    logic        dec_valid_o;
    logic [31:0] dec_instr_o;
    logic [31:0] dec_pc_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] prev_word = '0;

    localparam logic [31:0] END_PC = 32'h88;

    always #2.5 clk = ~clk;

    fetch_seq u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .stall_i(stall_i),
        .br_taken_i(br_taken_i), .br_target_i(br_target_i),
        .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
        .dec_valid_o(dec_valid_o), .dec_instr_o(dec_instr_o), .dec_pc_o(dec_pc_o)
    );

    // Program: taken branch at 0x10 -> 0x40, not-taken at 0x48, taken at 0x50 -> 0x80.
    // Branch word: opcode 000100 in [31:26], outcome in [25], target in [15:0].
    function automatic logic [31:0] prog(input logic [31:0] a);
        case (a)
            32'h10:  return {6'b000100, 1'b1, 9'b0, 16'h0040};
            32'h48:  return {6'b000100, 1'b0, 9'b0, 16'h0020};
            32'h50:  return {6'b000100, 1'b1, 9'b0, 16'h0080};
            default: return {6'b001101, 10'b0, a[15:0]};
        endcase
    endfunction

    assign imem_data_i = prog(imem_addr_o);

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] n_valid;
        logic [31:0] n_cyc;
        logic [31:0] pen;
        logic [31:0] pc_sum;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'b00, 32'd15, 32'd15, 32'd0, 32'd900},
        '{2'b01, 32'd13, 32'd16, 32'd1, 32'd796},
        '{2'b10, 32'd13, 32'd19, 32'd2, 32'd796},
        '{2'b11, 32'd13, 32'd19, 32'd2, 32'd796}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Comparator model: decode-stage outcome, or the previous decode word in late modes.
    task automatic drive_env(input logic [1:0] m);
        logic [31:0] now_w;
        logic [31:0] use_w;
        now_w = dec_valid_o ? dec_instr_o : 32'h0;
        use_w = m[1] ? prev_word : now_w;
        br_taken_i  = (use_w[31:26] == 6'b000100) && use_w[25];
        br_target_i = {16'h0, use_w[15:0]};
        prev_word   = now_w;
    endtask

    task automatic do_reset(input logic [1:0] m);
        mode_i = m; rst = 1'b1; stall_i = 1'b0; br_taken_i = 1'b0;
        br_target_i = '0; prev_word = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step_to(input logic [31:0] pc, input logic [1:0] m);
        for (int i = 0; i < 100; i++) begin
            if (dec_valid_o && dec_pc_o == pc) return;
            drive_env(m);
            @(negedge clk);
        end
        chk("R2", "reach pc", dec_pc_o, pc);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 / R7: reset state
        repeat (2) @(negedge clk);
        chk("R1", "valid after reset", {31'b0, dec_valid_o}, 32'h0);
        chk("R7", "bubble word after reset", dec_instr_o, 32'h0);
        chk("R1", "fetch address after reset", imem_addr_o, 32'h0);

        // Program runs per mode: R2, R4, R5, R6, R9
        for (int v = 0; v < 4; v++) begin
            int nv, nc;
            logic [31:0] sum;
            bit ok, seen;
            do_reset(VECS[v].mode);
            nv = 0; nc = 0; sum = '0; ok = 1'b1; seen = 1'b0;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (dec_valid_o) seen = 1'b1;
                if (seen) nc++;
                if (dec_valid_o) begin
                    nv++;
                    sum += dec_pc_o;
                    if (dec_instr_o !== prog(dec_pc_o)) ok = 1'b0;
                end
                if (!dec_valid_o && dec_instr_o !== 32'h0) ok = 1'b0;
                drive_env(VECS[v].mode);
                if (dec_valid_o && dec_pc_o == END_PC) break;
            end
            chk("R2", "word matches its pc", {31'b0, ok}, 32'h1);
            chk("R4 R5 R6", "valid issues", nv, VECS[v].n_valid);
            chk("R9", "decode cycles", nc, VECS[v].n_cyc);
            chk("R9", "penalty per branch", (nc - nv) / 3, VECS[v].pen);
            chk("R4 R5 R6", "sum of issued pcs", sum, VECS[v].pc_sum);
        end

        // R8: stall holds address and slot
        do_reset(2'b00);
        step_to(32'h8, 2'b00);
        stall_i = 1'b1;
        @(negedge clk);
        chk("R8", "slot pc in stall", dec_pc_o, 32'h8);
        chk("R8", "fetch addr in stall", imem_addr_o, 32'hC);
        @(negedge clk);
        chk("R8", "fetch addr second stall", imem_addr_o, 32'hC);
        stall_i = 1'b0;
        drive_env(2'b00);
        @(negedge clk);
        chk("R2", "slot pc after stall", dec_pc_o, 32'hC);

        // R8 with R4: stall and taken redirect in the same cycle
        do_reset(2'b00);
        step_to(32'h10, 2'b00);
        drive_env(2'b00);
        stall_i = 1'b1;
        @(negedge clk);
        chk("R8", "branch held in decode", dec_pc_o, 32'h10);
        chk("R8", "redirect deferred", imem_addr_o, 32'h14);
        stall_i = 1'b0;
        @(negedge clk);
        chk("R4", "delay slot issued", {dec_valid_o, dec_pc_o[30:0]}, {1'b1, 31'h14});
        chk("R4", "target fetched", imem_addr_o, 32'h40);

        // R3: taken flag ignored for a non-branch
        do_reset(2'b00);
        step_to(32'h4, 2'b00);
        br_taken_i = 1'b1; br_target_i = 32'h200;
        @(negedge clk);
        chk("R3", "no redirect on non-branch", imem_addr_o, 32'hC);
        chk("R3", "slot continues", dec_pc_o, 32'h8);

        // R6: late mode ignores the outcome while the branch is in decode
        do_reset(2'b10);
        step_to(32'h10, 2'b10);
        br_taken_i = 1'b1; br_target_i = 32'h200;
        @(negedge clk);
        chk("R6", "first bubble", {31'b0, dec_valid_o}, 32'h0);
        chk("R7", "first bubble word", dec_instr_o, 32'h0);
        chk("R6", "address held", imem_addr_o, 32'h14);
        br_taken_i = 1'b1; br_target_i = 32'h40;
        @(negedge clk);
        chk("R6", "second bubble", {31'b0, dec_valid_o}, 32'h0);
        chk("R6", "target fetched", imem_addr_o, 32'h40);
        br_taken_i = 1'b0;
        @(negedge clk);
        chk("R6", "target in decode", dec_pc_o, 32'h40);

        // R5: not-taken branch refetches the next address
        do_reset(2'b01);
        step_to(32'h48, 2'b01);
        drive_env(2'b01);
        @(negedge clk);
        chk("R5", "bubble after branch", {31'b0, dec_valid_o}, 32'h0);
        chk("R5", "refetch address", imem_addr_o, 32'h4C);
        drive_env(2'b01);
        @(negedge clk);
        chk("R5", "fall-through issued", dec_pc_o, 32'h4C);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule